// File: doc/BRIEF.md
# Multi-Channel Programmable Input Debouncer

This block is the front end for up to eight external, input-only event lines. Each raw line first passes through a two-flop synchronizer. It then goes through a per-channel debounce counter that advances once per millisecond tick. A new level becomes the channel's accepted level only after it has held without a break for the programmed number of milliseconds. When the accepted level changes to the polarity chosen for that channel, the channel sets a sticky status flag once. An interrupt output combines every flag that is not masked.

The debounce time of each channel is a 12-bit register, counted in milliseconds, with a range of 1 to 4000. The millisecond tick comes from a divider on the reference clock. A clock-enable output tells an external gating cell when any enabled channel still has counting to do. The output drops as soon as every enabled channel has settled.

Top module: `multi_debouncer`

## Requirements
- R1: Writing address i (0 to N_CH-1) sets channel i's debounce length L from the low 12 bits of `wr_data`. A value of 0 is stored as 1, and values above 4000 are stored as 4000. Reading the same address returns the stored value.
- R2: A new synchronized level on an enabled channel is accepted only after it has been present at L+1 consecutive `ms_tick` pulses. A change that lasts L tick periods or less, including any change shorter than one millisecond, leaves the accepted level unchanged.
- R3: If the input returns to the accepted level before acceptance, the count restarts from zero. Mismatch intervals that are each too short are never added together.
- R4: An accepted change sets status bit i when the new level matches trigger bit i (register 9): 1 selects a change to high and 0 selects a change to low. A change to the other polarity only updates the accepted level (register 12, read-only).
- R5: Each accepted change sets status exactly once. Holding the new level causes no further events. Writing 1 to a bit of register 11 clears that status bit.
- R6: `irq` is high exactly when some status bit is set and its mask bit (register 10, 1 = blocked) is clear.
- R7: A channel whose enable bit (register 8) is 0 does not count and never raises status. Its accepted level follows its synchronized input.
- R8: `cnt_clk_en` is low when every enabled channel's synchronized input equals its accepted level and no counter is running. It rises on the first mismatch on an enabled channel, at most 3 cycles after the raw input changes.
- R9: `ms_tick` is a one-cycle pulse once every TICK_DIV reference clock cycles.
- R10: After reset, all control and status registers and accepted levels are 0, every debounce length reads 1, and `irq` and `cnt_clk_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | N_CH | Raw asynchronous event inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ms_tick | output | 1 | Millisecond tick pulse |
| cnt_clk_en | output | 1 | Request to run the counting clock |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The bench builds the block with TICK_DIV = 4, so that one millisecond lasts four reference cycles. This lets hundreds of debounce windows, including the 0 and 1 limits, fit in a short run. Debounce lengths of 1 to 5 ms then bring both sides of the acceptance boundary within reach. Short pulses of at most L*4 cycles and long holds of at least (L+1)*4+3 cycles are drawn at random against a level model kept in the bench. Clamping at the 4000 end is checked through register read-back only.

// File: rtl/deb_pkg.sv
package deb_pkg;
  localparam int DB_W   = 12;
  localparam int DB_MAX = 4000;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_EN    = 4'd8;
  localparam logic [ADDR_W-1:0] A_TRIG  = 4'd9;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd10;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd11;
  localparam logic [ADDR_W-1:0] A_LEVEL = 4'd12;

  // Bring a written debounce length into the legal 1..DB_MAX window.
  function automatic logic [DB_W-1:0] f_clamp(input logic [DB_W-1:0] v);
    if (v == '0) return DB_W'(1);
    if (v > DB_W'(DB_MAX)) return DB_W'(DB_MAX);
    return v;
  endfunction

  // An accepted change is an event when it reaches the selected level.
  function automatic logic f_is_event(input logic new_lvl, input logic trig_hi);
    return new_lvl == trig_hi;
  endfunction
endpackage

// File: rtl/deb_tick_gen.sv
module deb_tick_gen #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign tick = wrap;
endmodule

// File: rtl/deb_channel.sv
module deb_channel
  import deb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic            en,
  input  logic            tick,
  input  logic [DB_W-1:0] limit,
  output logic            sync_lvl,
  output logic            acc_lvl,
  output logic            busy,
  output logic            accept
);
  logic [1:0]      sff_q;
  logic [DB_W-1:0] cnt_q;
  logic            acc_q;
  logic            differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sff_q <= '0;
    else        sff_q <= {sff_q[0], raw};
  end

  assign sync_lvl = sff_q[1];
  assign differs  = sync_lvl ^ acc_q;
  assign accept   = en && differs && tick && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      acc_q <= sync_lvl;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == limit) begin
        acc_q <= sync_lvl;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign acc_lvl = acc_q;
  assign busy    = (cnt_q != '0);
endmodule

// File: rtl/deb_regs.sv
module deb_regs
  import deb_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [N_CH-1:0]            fire,
  input  logic [N_CH-1:0]            acc_vec,
  output logic [N_CH-1:0][DB_W-1:0]  lim,
  output logic [N_CH-1:0]            en,
  output logic [N_CH-1:0]            trig,
  output logic [N_CH-1:0]            mask,
  output logic [N_CH-1:0]            status
);
  logic [N_CH-1:0] w1c;

  assign w1c = (wr_en && wr_addr == A_STAT) ? wr_data[N_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) lim[i] <= DB_W'(1);
      en     <= '0;
      trig   <= '0;
      mask   <= '0;
      status <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++)
        if (wr_en && wr_addr == ADDR_W'(i)) lim[i] <= f_clamp(wr_data[DB_W-1:0]);
      if (wr_en && wr_addr == A_EN)   en   <= wr_data[N_CH-1:0];
      if (wr_en && wr_addr == A_TRIG) trig <= wr_data[N_CH-1:0];
      if (wr_en && wr_addr == A_MASK) mask <= wr_data[N_CH-1:0];
      status <= (status & ~w1c) | fire;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = DATA_W'(lim[i]);
    case (rd_addr)
      A_EN:    rd_data = DATA_W'(en);
      A_TRIG:  rd_data = DATA_W'(trig);
      A_MASK:  rd_data = DATA_W'(mask);
      A_STAT:  rd_data = DATA_W'(status);
      A_LEVEL: rd_data = DATA_W'(acc_vec);
      default: ;
    endcase
  end
endmodule

// File: rtl/multi_debouncer.sv
module multi_debouncer
  import deb_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int TICK_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   din,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [3:0]        rd_addr,
  output logic [15:0]       rd_data,
  output logic              ms_tick,
  output logic              cnt_clk_en,
  output logic              irq
);
  logic [N_CH-1:0][DB_W-1:0] lim_q;
  logic [N_CH-1:0] en_q, trig_q, mask_q, status_q;
  logic [N_CH-1:0] sync_vec, acc_vec, busy_vec, accept_vec, fire_vec;

  deb_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (ms_tick)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    deb_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (din[i]),
      .en      (en_q[i]),
      .tick    (ms_tick),
      .limit   (lim_q[i]),
      .sync_lvl(sync_vec[i]),
      .acc_lvl (acc_vec[i]),
      .busy    (busy_vec[i]),
      .accept  (accept_vec[i])
    );
    assign fire_vec[i] = accept_vec[i] && f_is_event(sync_vec[i], trig_q[i]);
  end

  deb_regs #(.N_CH(N_CH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .fire   (fire_vec),
    .acc_vec(acc_vec),
    .lim    (lim_q),
    .en     (en_q),
    .trig   (trig_q),
    .mask   (mask_q),
    .status (status_q)
  );

  assign cnt_clk_en = (|(en_q & (sync_vec ^ acc_vec))) | (|busy_vec);
  assign irq        = |(status_q & ~mask_q);
endmodule

// File: rtl/multi_debouncer_chk.sv
module multi_debouncer_chk
  import deb_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int TICK_DIV = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ms_tick,
  input logic                      cnt_clk_en,
  input logic [N_CH-1:0]           fire_vec,
  input logic [N_CH-1:0]           sync_vec,
  input logic [N_CH-1:0]           acc_vec,
  input logic [N_CH-1:0]           busy_vec,
  input logic [N_CH-1:0]           en_q,
  input logic [N_CH-1:0]           status_q,
  input logic [N_CH-1:0][DB_W-1:0] lim_q
);
  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap <= 0;
    else if (ms_tick) gap <= 0;
    else              gap <= gap + 1;
  end

  p_tick_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |-> (gap == TICK_DIV - 1));

  p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gap < TICK_DIV);

  for (genvar i = 0; i < N_CH; i++) begin : g_lim
    p_lim_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_q[i] >= DB_W'(1)) && (lim_q[i] <= DB_W'(DB_MAX)));
  end

  p_accept_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (((acc_vec ^ $past(acc_vec)) & $past(en_q)) != '0) |-> $past(ms_tick));

  p_fire_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec != '0) |=> ((status_q & $past(fire_vec)) == $past(fire_vec)));

  p_single_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_vec != '0) |=> ((fire_vec & $past(fire_vec)) == '0));

  p_disabled_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_vec ^ $past(sync_vec)) & ~$past(en_q)) == '0);

  p_busy_needs_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_vec != '0) |-> cnt_clk_en);
endmodule

bind multi_debouncer multi_debouncer_chk #(.N_CH(N_CH), .TICK_DIV(TICK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ms_tick   (ms_tick),
  .cnt_clk_en(cnt_clk_en),
  .fire_vec  (fire_vec),
  .sync_vec  (sync_vec),
  .acc_vec   (acc_vec),
  .busy_vec  (busy_vec),
  .en_q      (en_q),
  .status_q  (status_q),
  .lim_q     (lim_q)
);

// File: tb/multi_debouncer_bench.sv
`timescale 1ns/1ps
module multi_debouncer_bench;
  localparam int N_CH = 8;
  localparam int DIV  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ms_tick, cnt_clk_en, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  multi_debouncer #(.N_CH(N_CH), .TICK_DIV(DIV)) u_multi_debouncer (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ms_tick(ms_tick), .cnt_clk_en(cnt_clk_en), .irq(irq)
  );

  function automatic int f_eff_len(input int v);
    if (v == 0) return 1;
    if (v > 4000) return 4000;
    return v;
  endfunction

  function automatic int f_settle(input int len);
    return (len + 2) * DIV + 8;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int ticks;
    logic lvl;
    process::self().srandom(32'd1234);

    idle(5);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk("R10 irq", 16'(irq), 16'h0);
    chk("R10 clk_en", 16'(cnt_clk_en), 16'h0);
    rd(4'd11, v); chk("R10 status", v, 16'h0);
    rd(4'd12, v); chk("R10 level", v, 16'h0);
    rd(4'd8, v);  chk("R10 enable", v, 16'h0);
    rd(4'd0, v);  chk("R10 len0", v, 16'd1);

    // R9 tick rate
    ticks = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ms_tick) ticks++;
    end
    chk("R9 ticks per 40", 16'(ticks), 16'd10);

    // R1 clamping
    wr(4'd3, 16'd0);    rd(4'd3, v); chk("R1 zero", v, 16'd1);
    wr(4'd4, 16'hFFFF); rd(4'd4, v); chk("R1 max", v, 16'd4000);
    wr(4'd5, 16'd4001); rd(4'd5, v); chk("R1 over", v, 16'd4000);
    wr(4'd6, 16'd4000); rd(4'd6, v); chk("R1 top", v, 16'd4000);
    wr(4'd7, 16'd37);   rd(4'd7, v); chk("R1 mid", v, 16'd37);

    // Setup
    wr(4'd0, 16'd3);
    wr(4'd1, 16'd2);
    wr(4'd2, 16'd2);
    wr(4'd8, 16'h07);
    wr(4'd9, 16'h01);
    wr(4'd10, 16'h00);

    // R2/R4/R6 rising event on ch0
    @(negedge clk); din[0] = 1'b1;
    idle(f_settle(3));
    rd(4'd12, v); chk("R2 ch0 accepted high", v & 16'h1, 16'h1);
    rd(4'd11, v); chk("R4 ch0 status", v, 16'h1);
    chk("R6 irq on", 16'(irq), 16'h1);

    // R5 single trigger and clear
    idle(60);
    wr(4'd11, 16'h1);
    rd(4'd11, v); chk("R5 cleared", v, 16'h0);
    chk("R5 irq off", 16'(irq), 16'h0);
    idle(40);
    rd(4'd11, v); chk("R5 no refire on hold", v, 16'h0);

    // R4 wrong polarity on ch0
    @(negedge clk); din[0] = 1'b0;
    idle(f_settle(3));
    rd(4'd12, v); chk("R4 ch0 accepted low", v & 16'h1, 16'h0);
    rd(4'd11, v); chk("R4 fall ignored for rising ch", v, 16'h0);

    // R4 falling trigger on ch1
    @(negedge clk); din[1] = 1'b1;
    idle(f_settle(2));
    rd(4'd11, v); chk("R4 ch1 rise no event", v, 16'h0);
    rd(4'd12, v); chk("R4 ch1 level high", v & 16'h2, 16'h2);
    @(negedge clk); din[1] = 1'b0;
    idle(f_settle(2));
    rd(4'd11, v); chk("R4 ch1 fall event", v, 16'h2);
    wr(4'd11, 16'h2);

    // R6 mask
    wr(4'd10, 16'h01);
    @(negedge clk); din[0] = 1'b1;
    idle(f_settle(3));
    rd(4'd11, v); chk("R6 masked status", v, 16'h1);
    chk("R6 masked irq", 16'(irq), 16'h0);
    wr(4'd10, 16'h00);
    idle(1);
    chk("R6 unmasked irq", 16'(irq), 16'h1);
    wr(4'd11, 16'h1);
    @(negedge clk); din[0] = 1'b0;
    idle(f_settle(3));

    // R2 glitch of one tick period with L=1
    wr(4'd0, 16'd1);
    @(negedge clk); din[0] = 1'b1;
    idle(DIV);
    din[0] = 1'b0;
    idle(f_settle(1));
    rd(4'd12, v); chk("R2 short glitch level", v & 16'h1, 16'h0);
    rd(4'd11, v); chk("R2 short glitch status", v, 16'h0);

    // R3 restart on return to accepted level
    wr(4'd0, 16'd3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); din[0] = 1'b1;
      idle(3 * DIV - 2);
      din[0] = 1'b0;
      idle(2);
    end
    idle(f_settle(3));
    rd(4'd12, v); chk("R3 no accumulation", v & 16'h1, 16'h0);
    rd(4'd11, v); chk("R3 no event", v, 16'h0);

    // R7 disabled channel follows, no event
    wr(4'd9, 16'h09);
    @(negedge clk); din[3] = 1'b1;
    idle(4);
    rd(4'd12, v); chk("R7 disabled follows", v & 16'h8, 16'h8);
    idle(f_settle(3));
    rd(4'd11, v); chk("R7 disabled no status", v, 16'h0);

    // R8 clock enable
    wr(4'd9, 16'h0D);
    idle(2);
    chk("R8 idle low", 16'(cnt_clk_en), 16'h0);
    @(negedge clk); din[2] = 1'b1;
    idle(3);
    chk("R8 mismatch high", 16'(cnt_clk_en), 16'h1);
    idle(f_settle(2));
    chk("R8 settled low", 16'(cnt_clk_en), 16'h0);
    rd(4'd11, v); chk("R8 ch2 rise event", v, 16'h4);
    wr(4'd11, 16'h4);

    // Random pulses on ch2
    lvl = 1'b1;
    for (int it = 0; it < 60; it++) begin
      int raw_len, len, d;
      bit lng;
      logic exp_lvl;
      logic [15:0] exp_st;
      raw_len = int'($urandom_range(0, 5));
      len = f_eff_len(raw_len);
      wr(4'd2, 16'(raw_len));
      lng = bit'($urandom_range(0, 1));
      if (lng) d = (len + 1) * DIV + 3 + int'($urandom_range(0, 20));
      else     d = 1 + int'($urandom_range(0, len * DIV - 1));
      @(negedge clk); din[2] = ~lvl;
      idle(d);
      if (!lng) din[2] = lvl;
      idle(f_settle(len));
      exp_lvl = lng ? ~lvl : lvl;
      exp_st  = (lng && exp_lvl) ? 16'h4 : 16'h0;
      rd(4'd12, v); chk("R2 random level", v & 16'h4, exp_lvl ? 16'h4 : 16'h0);
      rd(4'd11, v); chk("R5 random status", v, exp_st);
      wr(4'd11, 16'h4);
      lvl = exp_lvl;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule